// File: doc/BRIEF.md
# Multi-Domain Return-Clock Join

When several cores on one die each run on their own clock, every core needs its own test-clock synchronizer. Each synchronizer takes the test clock straight from the debug port and sends back its own return clock, delayed by a few cycles of its core clock. The debugger can follow only one return clock. This block combines the N per-domain return clocks into that single return clock. The combined level moves to a new value only after every input has already reached that value. The debugger is therefore always paced by the slowest domain, whatever the relationship between the core clocks.

The join is a state-holding element with N inputs and no clock of its own. A wide AND of the inputs tells it when to raise the output. A wide OR of the inputs tells it when to drop the output. For any mixed pattern of inputs the output keeps its level. An asynchronous reset forces the output low. The design uses only a parameterized reduction stage and a level-sensitive hold cell, so it works for any number of domains.

Top module: `rtck_join`

## Requirements
- R1: While `rst_i` is 1, `rtck_o` is 0, whatever the inputs are, and this includes all inputs being 1.
- R2: While `rtck_o` is 0 and reset is released, `rtck_o` becomes 1 once every bit of `rtck_i` is 1.
- R3: While `rtck_o` is 1 and reset is released, `rtck_o` becomes 0 once every bit of `rtck_i` is 0.
- R4: When `rtck_i` holds a mix of 0 and 1 bits, `rtck_o` keeps its previous level, whether that level is 0 or 1.
- R5: If every input is 1 when reset is released, `rtck_o` rises to 1 without any further input change.
- R6: The number of inputs N is a parameter. With N = 1 the output follows the single input.
- R7: When the inputs are driven by per-domain synchronizers on unrelated clocks, every edge of `rtck_o` occurs while all inputs already equal the new level. Over a run, `rtck_o` makes exactly one rising edge for each rising edge of the test clock and exactly one falling edge for each falling edge of the test clock.
- R8: The block has no clock. The output responds to the input that completes the agreement within the same time step, and no clock edge is needed in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_i | input | 1 | Asynchronous reset, active high; forces the combined output low |
| rtck_i | input | N | One return clock per synchronized domain |
| rtck_o | output | 1 | Combined return clock sent to the debugger |

## Verification
The bench builds the join twice. The first instance uses N = 4, which matches the usual four-domain setup. It is driven directly for the directed level and hold patterns. It is also driven by four bench-side synchronizers, whose core clocks have periods with no common relation, under an adaptive test clock that waits for the combined return clock. A second instance uses N = 1. It exercises the degenerate case, in which the join must reduce to a plain follower.

// File: rtl/rtckj_pkg.sv
package rtckj_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } rtck_lvl_e;

  // The hold cell may update only when the inputs agree: all high or all low.
  function automatic logic join_open(input logic all_hi, input logic any_hi);
    return all_hi | ~any_hi;
  endfunction

  // Level the hold cell takes when it is open.
  function automatic rtck_lvl_e join_level(input logic all_hi);
    return all_hi ? LVL_HIGH : LVL_LOW;
  endfunction

endpackage

// File: rtl/rtckj_reduce.sv
module rtckj_reduce #(
  parameter int N = 4
) (
  input  logic [N-1:0] vec_i,
  output logic         all_hi_o,
  output logic         any_hi_o
);
  localparam int CHAIN = N + 1;

  logic [CHAIN-1:0] and_chain;
  logic [CHAIN-1:0] or_chain;

  assign and_chain[0] = 1'b1;
  assign or_chain[0]  = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_stage
    assign and_chain[k+1] = and_chain[k] & vec_i[k];
    assign or_chain[k+1]  = or_chain[k]  | vec_i[k];
  end

  assign all_hi_o = and_chain[CHAIN-1];
  assign any_hi_o = or_chain[CHAIN-1];
endmodule

// File: rtl/rtckj_hold.sv
module rtckj_hold
  import rtckj_pkg::*;
(
  input  logic rst_i,
  input  logic all_hi_i,
  input  logic any_hi_i,
  output logic lvl_o
);
  rtck_lvl_e lvl_q;
  logic      open_w;

  assign open_w = join_open(all_hi_i, any_hi_i);

  // Intended level-sensitive storage: this is the state hold of the join.
  always_latch begin
    if (rst_i)
      lvl_q <= LVL_LOW;
    else if (open_w)
      lvl_q <= join_level(all_hi_i);
  end

  assign lvl_o = (lvl_q == LVL_HIGH);

  // R1: a rise is never allowed while reset is asserted.
  always @(posedge lvl_o) begin
    p_no_rise_in_reset_r1: assert (!rst_i)
      else $error("hold cell rose during reset");
  end
endmodule

// File: rtl/rtck_join.sv
module rtck_join #(
  parameter int N = 4
) (
  input  logic         rst_i,
  input  logic [N-1:0] rtck_i,
  output logic         rtck_o
);
  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};
  localparam logic [N-1:0] ALL_ZERO = {N{1'b0}};

  logic all_hi_w;
  logic any_hi_w;

  rtckj_reduce #(.N(N)) reduce_i (
    .vec_i    (rtck_i),
    .all_hi_o (all_hi_w),
    .any_hi_o (any_hi_w)
  );

  rtckj_hold hold_i (
    .rst_i    (rst_i),
    .all_hi_i (all_hi_w),
    .any_hi_i (any_hi_w),
    .lvl_o    (rtck_o)
  );

  // R2: a rise of the combined output needs every input already high.
  always @(posedge rtck_o) begin
    p_rise_all_high_r2: assert (rtck_i == ALL_ONES)
      else $error("combined output rose with inputs %b", rtck_i);
  end

  // R3: a fall outside reset needs every input already low.
  always @(negedge rtck_o) begin
    p_fall_all_low_r3: assert (rst_i || rtck_i == ALL_ZERO)
      else $error("combined output fell with inputs %b", rtck_i);
  end

  // R4: no edge at all is allowed while the inputs are mixed.
  always @(rtck_o) begin
    p_hold_mixed_r4: assert (rst_i || rtck_i == ALL_ONES || rtck_i == ALL_ZERO)
      else $error("combined output moved with mixed inputs %b", rtck_i);
  end
endmodule

// File: tb/rtck_join_tb_top.sv
`timescale 1ns/1ps

module rtckj_tb_sync (
  input  logic core_clk,
  input  logic rst,
  input  logic tck,
  output logic rtck
);
  logic s1, s2;
  always_ff @(posedge core_clk or posedge rst) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; rtck <= 1'b0;
    end else begin
      s1 <= tck; s2 <= s1; rtck <= s2;
    end
  end
endmodule

module rtck_join_tb_top;
  localparam int N = 4;
  localparam int TCK_EDGES = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] cclk = '0;
  always #3.65  cclk[0] = ~cclk[0];
  always #5.95  cclk[1] = ~cclk[1];
  always #6.55  cclk[2] = ~cclk[2];
  always #11.85 cclk[3] = ~cclk[3];

  logic         rst = 1'b1;
  logic         use_sync = 1'b0;
  logic         tck = 1'b0;
  logic         monitor_on = 1'b0;
  logic [N-1:0] drv = '0;
  logic [N-1:0] sync_rt;
  logic [N-1:0] rt_in;
  logic         out;
  logic [0:0]   one_in = 1'b0;
  logic         one_out;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  int rises = 0;
  int falls = 0;
  bit done = 0;

  assign rt_in = use_sync ? sync_rt : drv;

  for (genvar k = 0; k < N; k++) begin : g_sync
    rtckj_tb_sync sync_i (.core_clk(cclk[k]), .rst(rst), .tck(tck), .rtck(sync_rt[k]));
  end

  rtck_join #(.N(N)) dut_i (.rst_i(rst), .rtck_i(rt_in), .rtck_o(out));
  rtck_join #(.N(1)) dut_one_i (.rst_i(rst), .rtck_i(one_in), .rtck_o(one_out));

  // R7 monitor: each output edge must see every input already at the new level.
  always @(out) begin
    if (monitor_on && !rst) begin
      if (rt_in !== {N{out}}) viol++;
      if (out === 1'b1) rises++;
      else if (out === 1'b0) falls++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [N-1:0] v);
    drv = v;
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    put('0);
    chk("R1 reset low, inputs 0", out, 1'b0);
    put('1);
    chk("R1 reset low, inputs all 1", out, 1'b0);
    rst = 1'b0;
    #1;
    chk("R5 rise on release with all 1", out, 1'b1);
    rst = 1'b1;
    #1;
    chk("R1 reset forces high output low", out, 1'b0);
    put('0);
    rst = 1'b0;
    #1;
    chk("R1 stays low after release with inputs 0", out, 1'b0);
  endtask

  task automatic t_rise_fall;
    put(4'b0001);
    chk("R4 hold low with 0001", out, 1'b0);
    put(4'b0111);
    chk("R4 hold low with 0111", out, 1'b0);
    put(4'b1111);
    chk("R2 R8 rise once last input high", out, 1'b1);
    put(4'b1110);
    chk("R4 hold high with 1110", out, 1'b1);
    put(4'b0100);
    chk("R4 hold high with 0100", out, 1'b1);
    put(4'b0000);
    chk("R3 R8 fall once last input low", out, 1'b0);
  endtask

  task automatic t_orders;
    put(4'b1000);
    put(4'b1100);
    put(4'b1101);
    chk("R4 hold low, other order 1101", out, 1'b0);
    put(4'b1111);
    chk("R2 rise, other order", out, 1'b1);
    put(4'b0111);
    put(4'b0011);
    put(4'b1011);
    chk("R4 hold high after input returns 1011", out, 1'b1);
    put(4'b1000);
    chk("R4 hold high with single 1", out, 1'b1);
    put(4'b0000);
    chk("R3 fall, other order", out, 1'b0);
    put(4'b1010);
    chk("R4 hold low after fall 1010", out, 1'b0);
    put(4'b0000);
  endtask

  task automatic t_single;
    one_in = 1'b1;
    #1;
    chk("R6 N=1 follows rise", one_out, 1'b1);
    one_in = 1'b0;
    #1;
    chk("R6 N=1 follows fall", one_out, 1'b0);
  endtask

  task automatic wait_out(input logic lvl);
    int t = 0;
    while (out !== lvl && t < 2000) begin
      @(posedge clk);
      t++;
    end
    if (out !== lvl) chk("R7 adaptive wait", out, lvl);
  endtask

  task automatic t_sync;
    rst = 1'b1;
    tck = 1'b0;
    use_sync = 1'b1;
    repeat (20) @(posedge clk);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    monitor_on = 1'b1;
    for (int e = 0; e < TCK_EDGES; e++) begin
      @(negedge clk);
      tck = ~tck;
      wait_out(tck);
      repeat (3) @(posedge clk);
    end
    repeat (20) @(posedge clk);
    monitor_on = 1'b0;
    chk_int("R7 no edge with disagreeing input", viol, 0);
    chk_int("R7 rising edges per tck", rises, TCK_EDGES / 2);
    chk_int("R7 falling edges per tck", falls, TCK_EDGES / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3;
    t_reset();
    t_rise_fall();
    t_orders();
    t_single();
    t_sync();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule